// File: doc/BRIEF.md
# Biphase Video Line Word Decoder

This block takes the sliced serial data of one video line and turns it into a packed 40-bit word. A sample strobe arrives at twice the half-bit-cell rate. The block counts line-start strobes from the start of each field and arms itself only on one target line of the first field. Once armed, it hunts through the half-cells it samples for a biphase-coded start pattern. It then decodes a fixed run of fifteen 8-bit words.

Only five of those words are kept: words 5, 11, 12, 13 and 14. Their bits pass through unchanged, but the words are reordered so that words 11 to 14 lead and word 5 trails. At the end of the fifteenth word the block pulses a done strobe. The packed word and an error flag update on that strobe and hold until the next one. The error flag reports any biphase violation in a kept bit. A separate buffer block downstream decides what to do with a line flagged as bad.

Top module: `vline_biphase_decoder`

## Requirements
- R1: After reset, line_done and line_err are 0 and line_data is all zeros.
- R2: Counting restarts at 0 on field_start, and each line_start adds one. Decoding is armed only by the line_start that brings the count to TARGET_LINE while first_field is high. A line reached with first_field low, or any other line number, never produces line_done.
- R3: Each half-cell spans SAMPLES_PER_HALF strobes of sample_en, counted from the first strobe after arming. Its value is line_in at strobe index SAMPLES_PER_HALF/2 (0-based). Values at other strobes have no effect.
- R4: A 1 bit is sent as a high half-cell then a low one, and a 0 bit as low then high. The start pattern is START_CODE in this encoding, MSB first. Word data begins at the half-cell right after the pattern. A line whose pattern differs gives no line_done.
- R5: If the start pattern has not completed by half-cell SEARCH_HALVES after arming, the line is abandoned and gives no line_done. A pattern completing exactly on half-cell SEARCH_HALVES is accepted.
- R6: Words are numbered 1 to 15 in order of arrival, and the first bit received in a word is its bit 7. line_data is laid out as [39:32] word 11, [31:24] word 12, [23:16] word 13, [15:8] word 14 and [7:0] word 5. Each bit keeps the value of its first half-cell.
- R7: line_err is 1 when any bit of words 5 or 11 to 14 has two equal half-cells. Equal half-cells in the other ten words leave line_err at 0 and do not change line_data.
- R8: line_done is a one-cycle pulse two clocks after the sample_en strobe that samples the last half-cell of word 15. line_data and line_err change only with that pulse and hold between pulses.
- R9: A line_start that does not arm a line abandons any hunt or decode in progress, so that line gives no line_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Oversampling strobe, SAMPLES_PER_HALF per half-cell |
| line_in | input | 1 | Sliced serial line data |
| line_start | input | 1 | One-cycle strobe at the start of each video line |
| field_start | input | 1 | One-cycle strobe at the start of each field, clears the line count |
| first_field | input | 1 | High while the current field is the first field |
| line_done | output | 1 | One-cycle strobe when a decoded line completes |
| line_err | output | 1 | Biphase violation seen in a kept bit of the completed line |
| line_data | output | 5*WORD_BITS | Packed kept words, held between line_done strobes |

## Verification
The line counter, the half-cell phase and the hunt or decode state are not visible at the ports. A fault in any of them shows only as a missing or extra line_done, or as a wrong line_data or line_err at the end of a line. A phase that is off by one strobe, or a bit counter that is off by one, corrupts every line it touches. It also moves the done strobe away from its fixed two-clock distance after the last sample, so it shows within the first decoded line. A slip in the hunt window, the field gate or the abort path appears only at its boundary: a pattern that completes on the last permitted half-cell, a neighbouring line number, or a line start arriving in the middle of a frame.

// File: rtl/vlbd_pkg.sv
package vlbd_pkg;

    localparam int NUM_WORDS = 15;
    localparam int NUM_KEEP  = 5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_DECODE = 2'd2
    } dec_state_e;

    // Slot of a word (0-based arrival index) in the packed result, -1 when dropped.
    // Slot 0 is the most significant byte.
    function automatic int keep_slot(input int word_idx);
        int slot;
        case (word_idx)
            10:      slot = 0;
            11:      slot = 1;
            12:      slot = 2;
            13:      slot = 3;
            4:       slot = 4;
            default: slot = -1;
        endcase
        return slot;
    endfunction

endpackage

// File: rtl/vlbd_line_gate.sv
module vlbd_line_gate #(
    parameter int TARGET_LINE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_start,
    input  logic line_start,
    input  logic first_field,
    output logic arm_o,
    output logic abort_o
);

    localparam int LINE_W = $clog2(TARGET_LINE + 2);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    typedef struct packed {
        logic [LINE_W-1:0] line_cnt;
        logic              arm;
        logic              abort;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d       = gate_q;
        gate_d.arm   = 1'b0;
        gate_d.abort = 1'b0;
        if (field_start) begin
            gate_d.line_cnt = '0;
        end else if (line_start) begin
            if (gate_q.line_cnt != LINE_MAX) begin
                gate_d.line_cnt = gate_q.line_cnt + 1'b1;
            end
            if (first_field && (gate_q.line_cnt + 1'b1 == LINE_W'(TARGET_LINE))) begin
                gate_d.arm = 1'b1;
            end else begin
                gate_d.abort = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign arm_o   = gate_q.arm;
    assign abort_o = gate_q.abort;

    assert_arm_on_first_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q.arm |-> ($past(line_start) && $past(first_field)));

    assert_arm_abort_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_q.arm && gate_q.abort));

endmodule

// File: rtl/vlbd_half_sampler.sv
module vlbd_half_sampler #(
    parameter int SAMPLES_PER_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic sample_en,
    input  logic line_in,
    output logic half_stb_o,
    output logic half_val_o
);

    localparam int PH_W = (SAMPLES_PER_HALF > 1) ? $clog2(SAMPLES_PER_HALF) : 1;
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(SAMPLES_PER_HALF / 2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SAMPLES_PER_HALF - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            stb;
        logic            val;
    } samp_t;

    samp_t samp_d, samp_q;

    always_comb begin
        samp_d     = samp_q;
        samp_d.stb = 1'b0;
        if (restart_i) begin
            samp_d.phase = '0;
        end else if (sample_en) begin
            if (samp_q.phase == PH_MID) begin
                samp_d.stb = 1'b1;
                samp_d.val = line_in;
            end
            if (samp_q.phase == PH_LAST) begin
                samp_d.phase = '0;
            end else begin
                samp_d.phase = samp_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign half_stb_o = samp_q.stb;
    assign half_val_o = samp_q.val;

    assert_half_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        samp_q.stb |-> $past(sample_en));

    assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        samp_q.phase <= PH_LAST);

endmodule

// File: rtl/vlbd_frame_decoder.sv
module vlbd_frame_decoder
    import vlbd_pkg::*;
#(
    parameter int                  WORD_BITS     = 8,
    parameter int                  START_BITS    = 8,
    parameter logic [START_BITS-1:0] START_CODE  = 8'h5D,
    parameter int                  SEARCH_HALVES = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          arm_i,
    input  logic                          abort_i,
    input  logic                          half_stb_i,
    input  logic                          half_val_i,
    output logic                          done_o,
    output logic                          err_o,
    output logic [NUM_KEEP*WORD_BITS-1:0] result_o
);

    localparam int RES_W       = NUM_KEEP * WORD_BITS;
    localparam int IDX_W       = $clog2(RES_W);
    localparam int CODE_HALVES = 2 * START_BITS;
    localparam int HC_W        = $clog2(SEARCH_HALVES + 1);
    localparam int WW          = $clog2(NUM_WORDS);
    localparam int BW          = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;

    function automatic logic [CODE_HALVES-1:0] encode_code(input logic [START_BITS-1:0] c);
        logic [CODE_HALVES-1:0] r;
        for (int i = 0; i < START_BITS; i++) begin
            r[2*i+1] = c[i];
            r[2*i]   = ~c[i];
        end
        return r;
    endfunction

    localparam logic [CODE_HALVES-1:0] CODE_PAT = encode_code(START_CODE);

    typedef struct packed {
        dec_state_e             state;
        logic [CODE_HALVES-1:0] shift;
        logic [HC_W-1:0]        hunt_cnt;
        logic                   half_sel;
        logic                   first;
        logic [WW-1:0]          word;
        logic [BW-1:0]          bpos;
        logic [RES_W-1:0]       acc;
        logic                   err;
        logic                   done;
        logic [RES_W-1:0]       res;
        logic                   res_err;
    } dec_t;

    dec_t dec_d, dec_q;

    int               slot;
    logic [IDX_W-1:0] idx;

    always_comb begin
        slot = keep_slot(int'(dec_q.word));
        if (slot >= 0) begin
            idx = IDX_W'((NUM_KEEP - 1 - slot) * WORD_BITS + (WORD_BITS - 1) - int'(dec_q.bpos));
        end else begin
            idx = '0;
        end

        dec_d      = dec_q;
        dec_d.done = 1'b0;
        if (arm_i) begin
            dec_d.state    = ST_HUNT;
            dec_d.shift    = '0;
            dec_d.hunt_cnt = '0;
            dec_d.half_sel = 1'b0;
            dec_d.word     = '0;
            dec_d.bpos     = '0;
            dec_d.acc      = '0;
            dec_d.err      = 1'b0;
        end else if (abort_i) begin
            dec_d.state = ST_IDLE;
        end else if (half_stb_i) begin
            case (dec_q.state)
                ST_HUNT: begin
                    dec_d.shift    = {dec_q.shift[CODE_HALVES-2:0], half_val_i};
                    dec_d.hunt_cnt = dec_q.hunt_cnt + 1'b1;
                    if (dec_d.shift == CODE_PAT) begin
                        dec_d.state = ST_DECODE;
                    end else if (dec_d.hunt_cnt == HC_W'(SEARCH_HALVES)) begin
                        dec_d.state = ST_IDLE;
                    end
                end
                ST_DECODE: begin
                    if (!dec_q.half_sel) begin
                        dec_d.first    = half_val_i;
                        dec_d.half_sel = 1'b1;
                    end else begin
                        dec_d.half_sel = 1'b0;
                        if (slot >= 0) begin
                            dec_d.acc[idx] = dec_q.first;
                            if (dec_q.first == half_val_i) begin
                                dec_d.err = 1'b1;
                            end
                        end
                        if (dec_q.bpos == BW'(WORD_BITS - 1)) begin
                            dec_d.bpos = '0;
                            if (dec_q.word == WW'(NUM_WORDS - 1)) begin
                                dec_d.state   = ST_IDLE;
                                dec_d.done    = 1'b1;
                                dec_d.res     = dec_d.acc;
                                dec_d.res_err = dec_d.err;
                            end else begin
                                dec_d.word = dec_q.word + 1'b1;
                            end
                        end else begin
                            dec_d.bpos = dec_q.bpos + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign done_o   = dec_q.done;
    assign err_o    = dec_q.res_err;
    assign result_o = dec_q.res;

    assert_done_from_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.done |-> ($past(dec_q.state) == ST_DECODE));

    assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.done |=> !dec_q.done);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_q.done |-> ($stable(dec_q.res) && $stable(dec_q.res_err)));

    assert_hunt_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.state == ST_HUNT) |-> (dec_q.hunt_cnt < HC_W'(SEARCH_HALVES)));

    assert_abort_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !arm_i) |=> (dec_q.state == ST_IDLE));

    assert_word_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.word <= WW'(NUM_WORDS - 1));

endmodule

// File: rtl/vline_biphase_decoder.sv
module vline_biphase_decoder
    import vlbd_pkg::*;
#(
    parameter int                    TARGET_LINE      = 16,
    parameter int                    SAMPLES_PER_HALF = 2,
    parameter int                    WORD_BITS        = 8,
    parameter int                    START_BITS       = 8,
    parameter logic [START_BITS-1:0] START_CODE       = 8'h5D,
    parameter int                    SEARCH_HALVES    = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample_en,
    input  logic                          line_in,
    input  logic                          line_start,
    input  logic                          field_start,
    input  logic                          first_field,
    output logic                          line_done,
    output logic                          line_err,
    output logic [NUM_KEEP*WORD_BITS-1:0] line_data
);

    logic arm;
    logic abort;
    logic half_stb;
    logic half_val;

    vlbd_line_gate #(
        .TARGET_LINE(TARGET_LINE)
    ) i_line_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_start(field_start),
        .line_start (line_start),
        .first_field(first_field),
        .arm_o      (arm),
        .abort_o    (abort)
    );

    vlbd_half_sampler #(
        .SAMPLES_PER_HALF(SAMPLES_PER_HALF)
    ) i_half_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (arm),
        .sample_en (sample_en),
        .line_in   (line_in),
        .half_stb_o(half_stb),
        .half_val_o(half_val)
    );

    vlbd_frame_decoder #(
        .WORD_BITS    (WORD_BITS),
        .START_BITS   (START_BITS),
        .START_CODE   (START_CODE),
        .SEARCH_HALVES(SEARCH_HALVES)
    ) i_frame_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm),
        .abort_i   (abort),
        .half_stb_i(half_stb),
        .half_val_i(half_val),
        .done_o    (line_done),
        .err_o     (line_err),
        .result_o  (line_data)
    );

    assert_done_excludes_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !line_done);

endmodule

// File: tb/test_vline_biphase_decoder.sv
module test_vline_biphase_decoder;

    localparam int         TGT    = 3;
    localparam int         SPH    = 2;
    localparam int         SRCH   = 40;
    localparam logic [7:0] SCODE  = 8'hB3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic        line_in = 1'b0;
    logic        line_start = 1'b0;
    logic        field_start = 1'b0;
    logic        first_field = 1'b0;
    logic        line_done;
    logic        line_err;
    logic [39:0] line_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cyc_last = 0;
    int done_cnt = 0;
    int done_cyc = 0;
    bit finished = 1'b0;
    logic [39:0] held_data = '0;
    logic        held_err = 1'b0;

    vline_biphase_decoder #(
        .TARGET_LINE     (TGT),
        .SAMPLES_PER_HALF(SPH),
        .WORD_BITS       (8),
        .START_BITS      (8),
        .START_CODE      (SCODE),
        .SEARCH_HALVES   (SRCH)
    ) i_vline_biphase_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .line_in    (line_in),
        .line_start (line_start),
        .field_start(field_start),
        .first_field(first_field),
        .line_done  (line_done),
        .line_err   (line_err),
        .line_data  (line_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && line_done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] word_val(input int seed, input int w);
        return 8'((seed * 89 + w * 37 + 19) ^ (seed << 3));
    endfunction

    // R6 layout: w11 w12 w13 w14 w5, MSB first
    function automatic logic [39:0] pack_exp(input int seed);
        return {word_val(seed, 11), word_val(seed, 12), word_val(seed, 13),
                word_val(seed, 14), word_val(seed, 5)};
    endfunction

    function automatic bit is_kept(input int w);
        return (w == 5) || (w >= 11 && w <= 14);
    endfunction

    task automatic half(input logic v, input bit glitch);
        for (int s = 0; s < SPH; s++) begin
            sample_en = 1'b1;
            line_in   = (glitch && s != SPH / 2) ? ~v : v;
            cyc_last  = cyc;
            @(negedge clk);
            sample_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic run_line(input bit ff, input int nlines, input int pre, input int err_k,
                            input int abort_k, input logic [7:0] cx, input bit glitch,
                            input int seed, input bit exp_done, input string req);
        logic [7:0] code;
        done_cnt = 0;
        code = SCODE ^ cx;
        first_field = ff;
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
        @(negedge clk);
        for (int l = 0; l < nlines; l++) begin
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        for (int p = 0; p < pre; p++) half(1'b0, glitch);
        for (int i = 7; i >= 0; i--) begin
            half(code[i], glitch);
            half(~code[i], glitch);
        end
        for (int k = 0; k < 120; k++) begin
            logic b;
            b = word_val(seed, k / 8 + 1)[7 - (k % 8)];
            if (k == abort_k) begin
                line_start = 1'b1;
                @(negedge clk);
                line_start = 1'b0;
                @(negedge clk);
            end
            half(b, glitch);
            if (k == err_k) half(b, glitch);
            else half(~b, glitch);
        end
        repeat (4) @(negedge clk);
        if (exp_done) begin
            held_data = pack_exp(seed);
            held_err  = (err_k >= 0) && is_kept(err_k / 8 + 1);
            chk({req, " R8 done count"}, 64'(done_cnt), 64'd1);
            chk({req, " R8 done timing"}, 64'(done_cyc), 64'(cyc_last + 2));
            chk({req, " R6 data"}, 64'(line_data), 64'(held_data));
            chk({req, " R7 err"}, 64'(line_err), 64'(held_err));
        end else begin
            chk({req, " no done"}, 64'(done_cnt), 64'd0);
            chk({req, " R8 data held"}, 64'(line_data), 64'(held_data));
            chk({req, " R8 err held"}, 64'(line_err), 64'(held_err));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", 64'(line_done), 64'd0);
        chk("R1 err", 64'(line_err), 64'd0);
        chk("R1 data", 64'(line_data), 64'd0);

        // R4 R6 clean lines with varied data and preambles
        for (int s = 0; s < 8; s++) run_line(1, TGT, 2 + s, -1, -1, 8'h00, 0, s, 1, "R4_R6 clean");

        // R7 error on every kept bit
        for (int w = 1; w <= 15; w++) begin
            if (is_kept(w)) begin
                for (int b = 0; b < 8; b++)
                    run_line(1, TGT, 3, (w - 1) * 8 + b, -1, 8'h00, 0, 20 + w + b, 1, "R7 kept err");
            end
        end
        // R7 errors in dropped words are ignored
        for (int w = 1; w <= 15; w++) begin
            if (!is_kept(w))
                run_line(1, TGT, 3, (w - 1) * 8 + (w % 8), -1, 8'h00, 0, 60 + w, 1, "R7 dropped err");
        end

        // R2 field and line gating
        run_line(0, TGT, 3, -1, -1, 8'h00, 0, 90, 0, "R2 second field");
        run_line(1, TGT - 1, 3, -1, -1, 8'h00, 0, 91, 0, "R2 early line");
        run_line(1, TGT + 1, 3, -1, -1, 8'h00, 0, 92, 0, "R9 line after target");
        run_line(1, TGT, 3, -1, -1, 8'h00, 0, 93, 1, "R2 recovery");

        // R4 wrong start pattern
        run_line(1, TGT, 3, -1, -1, 8'h10, 0, 94, 0, "R4 bad code");

        // R5 search window edge
        run_line(1, TGT, SRCH - 16, -1, -1, 8'h00, 0, 95, 1, "R5 last half ok");
        run_line(1, TGT, SRCH - 15, -1, -1, 8'h00, 0, 96, 0, "R5 timeout");

        // R9 abort mid-decode
        run_line(1, TGT, 3, -1, 50, 8'h00, 0, 97, 0, "R9 abort");

        // R3 only the middle strobe counts
        run_line(1, TGT, 3, -1, -1, 8'h00, 1, 98, 1, "R3 glitch");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule